// File: doc/BRIEF.md
# Eight-Line GPIO Controller with Interrupts

This block gives software control of eight general-purpose I/O lines over a simple APB-style register bus. Each line can be an input or an output. The block drives the output value and an output-enable for every line. It samples the input lines through a synchroniser and returns their values through a data window. In that window, the address bits select which lines a read or write touches. Software can therefore set or read a single line without a read-modify-write sequence.

Each line also has its own interrupt detector. The detector can be set to level mode (high or low) or to edge mode (rising, falling, or both edges). Edge events are held in a latch until software clears them by writing one to the matching bit. Level conditions are not latched: they follow the line directly. The block reports raw status, enabled (masked) status, and one combined interrupt output.

Every bus access completes in its access phase with no wait states. Read data is valid while `psel` is high and `pwrite` is low. A write takes effect at the clock edge on which `psel`, `penable` and `pwrite` are all high. The register bus carries no stream data, so it has no valid/ready back-pressure.

Top module: `gpio8_ctrl`

## Requirements
- R1: After reset, every configuration register, the output latch, `pin_out`, `pin_oe` and `irq_o` are zero.
- R2: A write to any address with `paddr[11:10]==0` is a data write. It updates only the output-latch bits whose bit is set in the mask `paddr[9:2]`.
- R3: A read in the data window returns, for each bit set in the mask `paddr[9:2]`, the output-latch bit if the line is an output, or else the synchronised pin. Every bit not set in the mask reads as zero.
- R4: Direction register at 0x400: a 1 makes the line an output. `pin_oe` equals this register and `pin_out` shows the output latch.
- R5: A data write to a line whose direction bit is 0 leaves that line's latch unchanged. If the line is later switched to output, it drives the old latch value.
- R6: Sense register at 0x404: a bit of 1 selects level mode. In level mode the raw bit equals the synchronised pin when the polarity bit is 1, and its inverse when the polarity bit is 0. It is never latched, and a clear has no effect on it.
- R7: In edge mode, when the both-edges bit is 0, the polarity register (0x40C) selects the edge that sets the latched raw bit: 1 for rising, 0 for falling. The opposite edge leaves the bit unchanged.
- R8: Both-edges register at 0x408: a bit of 1 latches an event on either edge, and the polarity bit is ignored.
- R9: Writing 1 to a bit of the clear register (0x41C) clears that line's latched event on the next clock. If a new event arrives in the same cycle, the event wins.
- R10: Enable register at 0x410. Masked status (0x418) is raw status (0x414) ANDed with enable. `irq_o` is the OR of the masked status bits, delayed by one clock.
- R11: Configuration registers read back their written value. Writes to raw status, masked status and clear leave the status unchanged, and the clear register reads as zero.
- R12: A pin value becomes visible to reads and detection exactly two clocks after it is sampled at `pin_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data, combinational in the access |
| pin_in | input | 8 | Asynchronous line inputs |
| pin_out | output | 8 | Line output values |
| pin_oe | output | 8 | Line output enables |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
The hardest case to reach is a clear write that lands on the same clock edge as a new edge event on the same line. The bench starts a clear transaction at the falling clock where the pin toggles. The two-stage synchroniser and the edge-detect register then put the event on the exact edge where the two-cycle bus write commits. The line uses both-edges mode and already holds a latched event, so a design in which the clear wins reads back zero. A design in which the event wins keeps the bit set.

// File: rtl/gpio8_pkg.sv
package gpio8_pkg;
  localparam int unsigned NLINE  = 8;
  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFF_DIR  = 12'h400;
  localparam logic [ADDR_W-1:0] OFF_LVL  = 12'h404;
  localparam logic [ADDR_W-1:0] OFF_BOTH = 12'h408;
  localparam logic [ADDR_W-1:0] OFF_POL  = 12'h40C;
  localparam logic [ADDR_W-1:0] OFF_EN   = 12'h410;
  localparam logic [ADDR_W-1:0] OFF_RAW  = 12'h414;
  localparam logic [ADDR_W-1:0] OFF_PEND = 12'h418;
  localparam logic [ADDR_W-1:0] OFF_CLR  = 12'h41C;

  typedef struct packed {
    logic [NLINE-1:0] dir;
    logic [NLINE-1:0] lvl;
    logic [NLINE-1:0] both;
    logic [NLINE-1:0] pol;
    logic [NLINE-1:0] en;
  } gpio_cfg_t;
endpackage

// File: rtl/gpio8_sync.sv
module gpio8_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '0;
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio8_regs.sv
module gpio8_regs
  import gpio8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [NLINE-1:0]  pwdata,
  output logic [NLINE-1:0]  prdata,
  input  logic [NLINE-1:0]  pin_sync,
  input  logic [NLINE-1:0]  irq_raw,
  input  logic [NLINE-1:0]  irq_pend,
  output gpio_cfg_t         cfg,
  output logic [NLINE-1:0]  data_q,
  output logic [NLINE-1:0]  clr_mask
);
  logic             wr_en;
  logic             in_win;
  logic [NLINE-1:0] win_mask;
  logic [NLINE-1:0] upd_mask;

  assign wr_en    = psel & penable & pwrite;
  assign in_win   = (paddr[ADDR_W-1:ADDR_W-2] == 2'b00);
  assign win_mask = paddr[NLINE+1:2];
  assign upd_mask = win_mask & cfg.dir;   // input lines keep their latch

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= '0;
      data_q <= '0;
    end else if (wr_en) begin
      if (in_win) begin
        data_q <= (data_q & ~upd_mask) | (pwdata & upd_mask);
      end else begin
        case (paddr)
          OFF_DIR:  cfg.dir  <= pwdata;
          OFF_LVL:  cfg.lvl  <= pwdata;
          OFF_BOTH: cfg.both <= pwdata;
          OFF_POL:  cfg.pol  <= pwdata;
          OFF_EN:   cfg.en   <= pwdata;
          default:  ;
        endcase
      end
    end
  end

  assign clr_mask = (wr_en && paddr == OFF_CLR) ? pwdata : '0;

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      if (in_win) begin
        prdata = ((data_q & cfg.dir) | (pin_sync & ~cfg.dir)) & win_mask;
      end else begin
        case (paddr)
          OFF_DIR:  prdata = cfg.dir;
          OFF_LVL:  prdata = cfg.lvl;
          OFF_BOTH: prdata = cfg.both;
          OFF_POL:  prdata = cfg.pol;
          OFF_EN:   prdata = cfg.en;
          OFF_RAW:  prdata = irq_raw;
          OFF_PEND: prdata = irq_pend;
          default:  prdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio8_irq.sv
module gpio8_irq #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_sync,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] both,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] en,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] raw,
  output logic [W-1:0] pend,
  output logic         irq_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] latch_q;
  logic [W-1:0] evt;

  for (genvar i = 0; i < W; i++) begin : g_line
    logic rise, fall;
    assign rise   = pin_sync[i] & ~prev_q[i];
    assign fall   = ~pin_sync[i] & prev_q[i];
    assign evt[i] = ~lvl[i] & (both[i] ? (rise | fall) : (pol[i] ? rise : fall));
    assign raw[i] = lvl[i] ? ~(pin_sync[i] ^ pol[i]) : latch_q[i];
  end

  assign pend = raw & en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      latch_q <= '0;
      irq_o   <= 1'b0;
    end else begin
      prev_q  <= pin_sync;
      latch_q <= (latch_q & ~clr_mask) | evt;   // a new event beats a clear
      irq_o   <= |pend;
    end
  end
endmodule

// File: rtl/gpio8_ctrl.sv
module gpio8_ctrl
  import gpio8_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [NLINE-1:0]  pwdata,
  output logic [NLINE-1:0]  prdata,
  input  logic [NLINE-1:0]  pin_in,
  output logic [NLINE-1:0]  pin_out,
  output logic [NLINE-1:0]  pin_oe,
  output logic              irq_o
);
  gpio_cfg_t        cfg;
  logic [NLINE-1:0] pin_sync;
  logic [NLINE-1:0] data_q;
  logic [NLINE-1:0] clr_mask;
  logic [NLINE-1:0] irq_raw;
  logic [NLINE-1:0] irq_pend;

  gpio8_sync #(.W(NLINE), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  gpio8_regs u_regs (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pin_sync(pin_sync),
    .irq_raw(irq_raw), .irq_pend(irq_pend), .cfg(cfg), .data_q(data_q),
    .clr_mask(clr_mask)
  );

  gpio8_irq #(.W(NLINE)) u_irq (
    .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync), .lvl(cfg.lvl),
    .both(cfg.both), .pol(cfg.pol), .en(cfg.en), .clr_mask(clr_mask),
    .raw(irq_raw), .pend(irq_pend), .irq_o(irq_o)
  );

  assign pin_out = data_q;
  assign pin_oe  = cfg.dir;
endmodule

// File: rtl/gpio8_ctrl_chk.sv
module gpio8_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        psel,
  input logic        penable,
  input logic        pwrite,
  input logic [11:0] paddr,
  input logic [7:0]  pwdata,
  input logic [7:0]  prdata,
  input logic [7:0]  pin_in,
  input logic [7:0]  pin_out,
  input logic [7:0]  pin_oe,
  input logic        irq_o,
  input logic [7:0]  sync_q,
  input logic [7:0]  irq_raw,
  input logic [7:0]  irq_en,
  input logic [7:0]  irq_lvl
);
  logic [1:0] age;
  logic [7:0] clr_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assign clr_v = (psel && penable && pwrite && paddr == 12'h41C) ? pwdata : 8'h00;

  // R3
  unmasked_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !pwrite && paddr[11:10] == 2'b00) |-> ((prdata & ~paddr[9:2]) == 8'h00));

  // R11
  clr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !pwrite && paddr == 12'h41C) |-> (prdata == 8'h00));

  // R12
  sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (sync_q == $past(pin_in, 2)));

  // R10
  irq_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1) |-> (irq_o == $past(|(irq_raw & irq_en))));

  // R9
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1) |->
    ((($past(irq_raw) & ~$past(irq_lvl) & ~irq_lvl & ~$past(clr_v)) & ~irq_raw) == 8'h00));

  // R5
  input_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && $past(pin_oe) == pin_oe) |->
    (((pin_out ^ $past(pin_out)) & ~pin_oe) == 8'h00));
endmodule

bind gpio8_ctrl gpio8_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pin_in(pin_in),
  .pin_out(pin_out), .pin_oe(pin_oe), .irq_o(irq_o), .sync_q(pin_sync),
  .irq_raw(irq_raw), .irq_en(cfg.en), .irq_lvl(cfg.lvl)
);

// File: tb/gpio8_ctrl_tb.sv
module gpio8_ctrl_tb_top;
  localparam time CLK_P = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [7:0]  pwdata = '0;
  logic [7:0]  prdata, pin_out, pin_oe;
  logic [7:0]  pin_in = '0;
  logic        irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  gpio8_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_o(irq_o)
  );

  // {dir, mask, wdata, pins, expected full-window read}
  localparam logic [39:0] VEC [0:4] = '{
    40'hFF_FF_A5_00_A5,
    40'hFF_0F_FF_00_0F,
    40'h0F_FF_FF_A0_AF,
    40'hF0_3C_FF_0F_3F,
    40'h00_FF_FF_55_55
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(posedge clk);
    #1 psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    @(posedge clk);
    #1 psel = 1'b0; penable = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 pin_oe", pin_oe, 8'h00);
    chk("R1 pin_out", pin_out, 8'h00);
    chk("R1 irq_o", {7'b0, irq_o}, 8'h00);
    for (int k = 0; k < 5; k++) begin
      rd(12'h400 + 12'(k * 4), v);
      chk("R1 config reg", v, 8'h00);
    end

    // R2 R3 table of masked data accesses
    for (int i = 0; i < 5; i++) begin
      logic [39:0] e;
      e = VEC[i];
      pin_in = e[15:8];
      wr(12'h400, 8'hFF);
      wr(12'h3FC, 8'h00);
      wr(12'h400, e[39:32]);
      wr({2'b00, e[31:24], 2'b00}, e[23:16]);
      wait_cyc(3);
      rd(12'h3FC, v);
      chk("R2/R3 table read", v, e[7:0]);
    end

    // R5 writes made while input did not stick
    wr(12'h400, 8'hFF);
    rd(12'h3FC, v);
    chk("R5 latch after switch to output", v, 8'h00);
    chk("R5 pin_out", pin_out, 8'h00);
    wr(12'h3FC, 8'hFF);
    chk("R4 pin_out", pin_out, 8'hFF);
    chk("R4 pin_oe", pin_oe, 8'hFF);
    rd(12'h204, v);
    chk("R3 partial mask read", v, 8'h81);
    wr(12'h408, 8'h3C);
    rd(12'h408, v);
    chk("R11 config readback", v, 8'h3C);
    wr(12'h408, 8'h00);

    // R12 synchroniser latency, bus held in a read of the window
    wr(12'h400, 8'h00);
    pin_in = 8'h00;
    wait_cyc(4);
    psel = 1'b1; penable = 1'b1; pwrite = 1'b0; paddr = 12'h3FC;
    @(negedge clk);
    pin_in = 8'hAA;
    @(negedge clk);
    #1 chk("R12 one clock", prdata, 8'h00);
    @(negedge clk);
    #1 chk("R12 two clocks", prdata, 8'hAA);
    psel = 1'b0; penable = 1'b0;
    pin_in = 8'h00;
    wait_cyc(4);
    wr(12'h41C, 8'hFF);
    wait_cyc(2);
    rd(12'h414, v);
    chk("R9 clear all", v, 8'h00);

    // R7 rising edge on line 0
    wr(12'h40C, 8'h01);
    wr(12'h410, 8'h01);
    pin_in = 8'h01;
    wait_cyc(5);
    rd(12'h414, v);
    chk("R7 rising latched", v, 8'h01);
    chk("R10 irq_o set", {7'b0, irq_o}, 8'h01);
    rd(12'h418, v);
    chk("R10 masked", v, 8'h01);
    pin_in = 8'h00;
    wait_cyc(5);
    rd(12'h414, v);
    chk("R7 falling ignored, held", v, 8'h01);
    // R11 status writes ignored
    wr(12'h414, 8'h00);
    wr(12'h418, 8'h00);
    rd(12'h414, v);
    chk("R11 raw write ignored", v, 8'h01);
    rd(12'h41C, v);
    chk("R11 clear reads zero", v, 8'h00);
    wr(12'h41C, 8'h01);
    wait_cyc(2);
    rd(12'h414, v);
    chk("R9 cleared", v, 8'h00);
    chk("R10 irq_o low", {7'b0, irq_o}, 8'h00);

    // R7 falling edge on line 1, not enabled
    pin_in = 8'h02;
    wait_cyc(5);
    rd(12'h414, v);
    chk("R7 rise ignored in falling mode", v, 8'h00);
    pin_in = 8'h00;
    wait_cyc(5);
    rd(12'h414, v);
    chk("R7 falling latched", v, 8'h02);
    rd(12'h418, v);
    chk("R10 masked off", v, 8'h00);
    chk("R10 irq_o stays low", {7'b0, irq_o}, 8'h00);
    wr(12'h41C, 8'h02);

    // R8 both edges on line 4, polarity 0 ignored
    wr(12'h408, 8'h10);
    pin_in = 8'h10;
    wait_cyc(5);
    rd(12'h414, v);
    chk("R8 rise latched", v, 8'h10);
    wr(12'h41C, 8'h10);
    wait_cyc(2);
    rd(12'h414, v);
    chk("R9 cleared line4", v, 8'h00);
    pin_in = 8'h00;
    wait_cyc(5);
    rd(12'h414, v);
    chk("R8 fall latched", v, 8'h10);

    // R9 clear coinciding with a new edge: edge wins
    pin_in = 8'h10;
    wait_cyc(5);
    @(negedge clk);
    pin_in = 8'h00;
    wr(12'h41C, 8'h10);
    wait_cyc(2);
    rd(12'h414, v);
    chk("R9 edge beats clear", v, 8'h10);
    wr(12'h41C, 8'h10);
    wait_cyc(2);
    rd(12'h414, v);
    chk("R9 plain clear", v, 8'h00);
    wr(12'h408, 8'h00);

    // R6 level high on line 2
    wr(12'h40C, 8'h05);
    wr(12'h404, 8'h04);
    wr(12'h410, 8'h04);
    pin_in = 8'h04;
    wait_cyc(4);
    rd(12'h414, v);
    chk("R6 level high", v, 8'h04);
    chk("R10 irq_o level", {7'b0, irq_o}, 8'h01);
    wr(12'h41C, 8'h04);
    wait_cyc(2);
    rd(12'h414, v);
    chk("R6 clear no effect", v, 8'h04);
    pin_in = 8'h00;
    wait_cyc(4);
    rd(12'h414, v);
    chk("R6 level drops", v, 8'h00);
    chk("R10 irq_o drops", {7'b0, irq_o}, 8'h00);

    // R6 level low on line 3
    wr(12'h404, 8'h0C);
    wait_cyc(1);
    rd(12'h414, v);
    chk("R6 level low", v, 8'h08);
    wr(12'h404, 8'h00);
    rd(12'h414, v);
    chk("R6 back to edge mode", v, 8'h00);

    wait_cyc(2);
    finish_run();
  end
endmodule